// File: doc/BRIEF.md
# Prescaled Supervision Timer Bank

This block measures time for the supervision functions of a signalling link controller. It holds a shared prescaler and eight independent supervision timers. The first two timers bound the time the link may spend in the aligned-ready and the not-aligned alignment states; expiry of either one signals a link failure to the surrounding logic. The remaining six serve other protocol supervision intervals. The block keeps no link state of its own. It only counts time and reports when each timer runs out.

A fixed base divider turns the system clock into a step every 32 cycles. The prescaler counts sixteen steps for each unit of an 8-bit setting and emits a shared tick. Each timer is started with a 16-bit period in two's-complement form. It counts upward once per tick and expires when its count wraps to zero. On expiry it raises a one-cycle pulse and returns to idle. The controller can restart a timer at any time or stop it quietly.

Top module: `sup_timer_bank`

## Requirements
- R1: After reset every running flag and every expiry pulse is low, and the prescaler phase restarts, so the first tick falls on the 512·D-th rising edge after reset is released, where D is the decoded prescaler setting.
- R2: The shared tick repeats every 512·D system clocks. D equals the setting for settings 1 to 255, and a setting of 0 decodes as D = 257, which gives 131584 clocks.
- R3: A timer started with period P expires on the (65536 − P)-th tick after the start edge, with P read as 16 unsigned bits. P = 0xFFFF expires on the first tick and P = 0 needs 65536 ticks. A tick on the start edge itself does not count.
- R4: An expiry drives that timer's expiry output high for exactly one cycle. The running flag falls on the same edge, and the timer stays idle until the next start.
- R5: A stop strobe without a start clears the running flag on the next edge and never produces an expiry pulse.
- R6: A start strobe on a running timer reloads its period and restarts the count. This holds even on the edge where it would have expired; in that case no pulse is issued and the timer keeps running.
- R7: Timers run independently on the shared tick. Each one expires at its own time, whatever the others are doing.
- R8: When start and stop arrive in the same cycle, the start wins and the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| presc_set_i | input | 8 | Prescaler setting; tick every 512·D clocks, 0 decodes as D = 257 |
| period_i | input | 128 | Eight 16-bit two's-complement periods; timer k uses bits [16k+15:16k] |
| start_i | input | 8 | Per-timer start strobe (loads period, sets running) |
| stop_i | input | 8 | Per-timer stop strobe (clears running, no pulse) |
| expire_o | output | 8 | Per-timer one-cycle expiry pulse |
| running_o | output | 8 | Per-timer running flag |

## Verification
Timers are started with periods of one, two, three and four ticks at prescaler settings 1, 2 and 0. This separates the linear tick scaling from the special decode of 0 and confirms that the two's-complement period sets the tick count. Starts placed at different phases of the tick show that the start edge never counts as a tick. A start laid exactly on an expiry edge, a stop before expiry and a start paired with a stop each distinguish which strobe has priority. Three timers launched together with different periods show that the timers do not interfere with one another.

// File: rtl/stb_pkg.sv
package stb_pkg;
  // Default geometry of the supervision timer bank
  localparam int STB_NUM_TMR  = 8;   // timers in the bank
  localparam int STB_TMR_W    = 16;  // timer count width
  localparam int STB_PS_W     = 8;   // prescaler setting width
  localparam int STB_BASE_DIV = 32;  // system clocks per base step
  localparam int STB_PS_MULT  = 16;  // base steps per setting unit
endpackage

// File: rtl/stb_base_div.sv
// Fixed divider: one base step every DIV system clocks.
module stb_base_div #(
  parameter int DIV = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last   = (cnt_q == CW'(DIV - 1));
  assign step_o = last;

  always_comb begin
    if (last) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stb_prescaler.sv
// Shared prescaler: counts MULT base steps per unit of the decoded
// setting and emits a one-cycle tick at the end of each period.
module stb_prescaler #(
  parameter int PSW  = 8,
  parameter int MULT = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  input  logic [PSW-1:0] set_i,
  output logic           tick_o
);
  localparam int MW = (MULT > 1) ? $clog2(MULT) : 1;
  localparam int LW = PSW + 1 + MW;

  logic [PSW:0]  units;
  logic [LW-1:0] lim_m1;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_end;

  // Zero selects the longest period: one unit beyond the full range.
  always_comb begin
    if (set_i == '0) units = {1'b1, {PSW{1'b0}}} + (PSW + 1)'(1);
    else             units = {1'b0, set_i};
  end

  assign lim_m1 = LW'(units) * LW'(MULT) - LW'(1);
  assign at_end = (cnt_q >= lim_m1);
  assign tick_o = step_i & at_end;
  assign cnt_en = step_i;

  always_comb begin
    if (at_end) cnt_d = '0;
    else        cnt_d = cnt_q + LW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stb_timer_slot.sv
// One supervision timer: loads a two's-complement period, counts up on
// each tick, and pulses once when the count wraps to zero.
module stb_timer_slot #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [TW-1:0] period_i,
  output logic          run_o,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          exp_q, exp_d;
  logic          cnt_en;
  logic          wrap;

  assign wrap = (cnt_q == {TW{1'b1}});

  // Priority: start, then stop, then counting.
  always_comb begin
    run_d  = run_q;
    cnt_d  = cnt_q;
    exp_d  = 1'b0;
    cnt_en = 1'b0;
    if (start_i) begin
      run_d  = 1'b1;
      cnt_d  = period_i;
      cnt_en = 1'b1;
    end else if (stop_i) begin
      run_d  = 1'b0;
    end else if (run_q && tick_i) begin
      cnt_d  = cnt_q + TW'(1);
      cnt_en = 1'b1;
      if (wrap) begin
        run_d = 1'b0;
        exp_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else begin
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_o = run_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/sup_timer_bank.sv
module sup_timer_bank
  import stb_pkg::*;
#(
  parameter int NUM_TMR  = STB_NUM_TMR,
  parameter int TMR_W    = STB_TMR_W,
  parameter int PS_W     = STB_PS_W,
  parameter int BASE_DIV = STB_BASE_DIV,
  parameter int PS_MULT  = STB_PS_MULT
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [PS_W-1:0]          presc_set_i,
  input  logic [NUM_TMR*TMR_W-1:0] period_i,
  input  logic [NUM_TMR-1:0]       start_i,
  input  logic [NUM_TMR-1:0]       stop_i,
  output logic [NUM_TMR-1:0]       expire_o,
  output logic [NUM_TMR-1:0]       running_o
);
  logic base_step;
  logic presc_tick;

  stb_base_div #(.DIV(BASE_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (base_step)
  );

  stb_prescaler #(.PSW(PS_W), .MULT(PS_MULT)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (base_step),
    .set_i  (presc_set_i),
    .tick_o (presc_tick)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_slot
    stb_timer_slot #(.TW(TMR_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (presc_tick),
      .start_i  (start_i[g]),
      .stop_i   (stop_i[g]),
      .period_i (period_i[g*TMR_W +: TMR_W]),
      .run_o    (running_o[g]),
      .exp_o    (expire_o[g])
    );
  end
endmodule

// File: rtl/stb_checker.sv
module stb_checker #(
  parameter int N    = 8,
  parameter int PSW  = 8,
  parameter int DIV  = 32,
  parameter int MULT = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic [PSW-1:0] pset,
  input logic [N-1:0]   start,
  input logic [N-1:0]   stop,
  input logic [N-1:0]   expire,
  input logic [N-1:0]   running
);
  localparam int GW = 24;

  logic [GW-1:0]  gap_q;
  logic           chg_q;
  logic [PSW-1:0] prev_q;
  logic [GW-1:0]  want_m1;

  always_comb begin
    if (pset == '0) want_m1 = GW'(DIV * MULT * ((1 << PSW) + 1) - 1);
    else            want_m1 = GW'(DIV * MULT) * GW'(pset) - GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      chg_q  <= 1'b1;
      prev_q <= '0;
    end else begin
      prev_q <= pset;
      gap_q  <= tick ? '0 : gap_q + GW'(1);
      if (tick)                chg_q <= 1'b0;
      else if (pset != prev_q) chg_q <= 1'b1;
    end
  end

  // R2: tick spacing matches the decoded setting while it is steady
  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !chg_q && pset == prev_q) |-> gap_q == want_m1);

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4: pulse lasts a single cycle
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> !expire[i]);
    // R4: running drops together with the pulse
    assert_exp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |-> !running[i]);
    // R3: expiry only follows a tick on a running timer
    assert_exp_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |-> ($past(tick) && $past(running[i])));
    // R5: a lone stop leaves the timer idle and silent
    assert_stop_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop[i] && !start[i]) |=> (!running[i] && !expire[i]));
    // R6, R8: a start always wins and suppresses the pulse
    assert_start_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start[i] |=> (running[i] && !expire[i]));
  end
endmodule

bind sup_timer_bank stb_checker #(
  .N(NUM_TMR), .PSW(PS_W), .DIV(BASE_DIV), .MULT(PS_MULT)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_ni),
  .tick    (presc_tick),
  .pset    (presc_set_i),
  .start   (start_i),
  .stop    (stop_i),
  .expire  (expire_o),
  .running (running_o)
);

// File: tb/sup_timer_bank_tb.sv
module sup_timer_bank_tb;
  localparam int NT = 8;
  localparam int TW = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic [7:0]        pset;
  logic [NT*TW-1:0]  per;
  logic [NT-1:0]     st, sp;
  logic [NT-1:0]     ex, rn;

  int ecnt;
  int npulse [NT];
  int last_exp [NT];
  int nchk = 0;
  int nfail = 0;

  sup_timer_bank u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .presc_set_i (pset),
    .period_i    (per),
    .start_i     (st),
    .stop_i      (sp),
    .expire_o    (ex),
    .running_o   (rn)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ecnt <= 0;
    else        ecnt <= ecnt + 1;

  initial for (int i = 0; i < NT; i++) begin npulse[i] = 0; last_exp[i] = -1; end

  always @(negedge clk)
    for (int i = 0; i < NT; i++)
      if (ex[i] === 1'b1) begin npulse[i]++; last_exp[i] = ecnt; end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_to(input int t);
    while (ecnt < t) step();
  endtask

  function automatic int pred(input int s, input int l, input int n);
    return (s / l + 1) * l + (n - 1) * l;
  endfunction

  task automatic do_reset(input logic [7:0] setting);
    step();
    rst_n = 1'b0; pset = setting; st = '0; sp = '0; per = '0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic launch(input int i, input logic [15:0] p, output int s);
    per[i*TW +: TW] = p;
    st[i] = 1'b1;
    s = ecnt + 1;
    step();
    st[i] = 1'b0;
  endtask

  task automatic check_expiry(input int i, input int e, input string tag);
    int n0;
    n0 = npulse[i];
    wait_to(e - 1);
    chk(rn[i] == 1'b1, {tag, " running before expiry"}, rn[i], 1);
    chk(ex[i] == 1'b0, {tag, " no early pulse"}, ex[i], 0);
    wait_to(e);
    chk(ex[i] == 1'b1, {tag, " pulse at predicted edge"}, ex[i], 1);
    chk(rn[i] == 1'b0, {tag, " running cleared with pulse"}, rn[i], 0);
    wait_to(e + 1);
    chk(ex[i] == 1'b0, {tag, " pulse one cycle only"}, ex[i], 0);
    chk(npulse[i] - n0 == 1, {tag, " single pulse"}, npulse[i] - n0, 1);
  endtask

  // R1: idle after reset, first tick phase fixed by reset
  task automatic t_reset();
    int s;
    do_reset(8'd1);
    chk(rn == '0, "R1 running after reset", rn, 0);
    chk(ex == '0, "R1 expire after reset", ex, 0);
    launch(0, 16'hFFFF, s);
    check_expiry(0, 512, "R1 first tick at 512");
  endtask

  // R3, R4: three-tick period at setting 1
  task automatic t_basic();
    int s;
    launch(0, 16'hFFFD, s);
    check_expiry(0, pred(s, 512, 3), "R3 three-tick period");
    repeat (600) step();
    chk(rn[0] == 1'b0 && npulse[0] == 2, "R4 stays idle after expiry", npulse[0], 2);
  endtask

  // R5: stop before expiry is silent
  task automatic t_stop();
    int s, e, n0;
    n0 = npulse[1];
    launch(1, 16'hFFFE, s);
    e = pred(s, 512, 2);
    wait_to(s + 20);
    sp[1] = 1'b1; step(); sp[1] = 1'b0;
    chk(rn[1] == 1'b0, "R5 stop clears running", rn[1], 0);
    wait_to(e + 2);
    chk(npulse[1] == n0, "R5 no pulse after stop", npulse[1], n0);
    chk(rn[1] == 1'b0, "R5 still idle", rn[1], 0);
  endtask

  // R6: restart on the expiry edge suppresses the pulse
  task automatic t_collide();
    int s, e, s2, n0;
    launch(2, 16'hFFFF, s);
    e = pred(s, 512, 1);
    n0 = npulse[2];
    wait_to(e - 1);
    launch(2, 16'hFFFF, s2);
    chk(s2 == e, "R6 start placed on expiry edge", s2, e);
    chk(ex[2] == 1'b0, "R6 pulse suppressed by start", ex[2], 0);
    chk(rn[2] == 1'b1, "R6 still running after restart", rn[2], 1);
    chk(npulse[2] == n0, "R6 no pulse counted", npulse[2], n0);
    check_expiry(2, e + 512, "R6 reloaded expiry");
  endtask

  // R8: start and stop together -> runs
  task automatic t_both();
    int s;
    per[4*TW +: TW] = 16'hFFFF;
    st[4] = 1'b1; sp[4] = 1'b1; s = ecnt + 1;
    step();
    st[4] = 1'b0; sp[4] = 1'b0;
    chk(rn[4] == 1'b1, "R8 start beats stop", rn[4], 1);
    check_expiry(4, pred(s, 512, 1), "R8 expiry after joint strobe");
  endtask

  // R7: independent timers on the shared tick
  task automatic t_indep();
    int s, e5, e6, e7;
    per[5*TW +: TW] = 16'hFFFF;
    per[6*TW +: TW] = 16'hFFFD;
    per[7*TW +: TW] = 16'hFFFC;
    st[7:5] = 3'b111; s = ecnt + 1;
    step();
    st[7:5] = 3'b000;
    e5 = pred(s, 512, 1); e6 = pred(s, 512, 3); e7 = pred(s, 512, 4);
    wait_to(e5 + 1);
    chk(rn[7:6] == 2'b11, "R7 others keep running", rn[7:6], 3);
    wait_to(e7 + 1);
    chk(last_exp[5] == e5, "R7 timer 5 expiry edge", last_exp[5], e5);
    chk(last_exp[6] == e6, "R7 timer 6 expiry edge", last_exp[6], e6);
    chk(last_exp[7] == e7, "R7 timer 7 expiry edge", last_exp[7], e7);
  endtask

  // R2: setting 2 doubles the tick, setting 0 decodes as 257
  task automatic t_scale();
    int s;
    do_reset(8'd2);
    launch(3, 16'hFFFE, s);
    check_expiry(3, pred(s, 1024, 2), "R2 setting 2 two ticks");
    do_reset(8'd0);
    launch(0, 16'hFFFF, s);
    check_expiry(0, 131584, "R2 setting 0 longest tick");
  endtask

  initial begin
    rst_n = 1'b0; pset = 8'd1; per = '0; st = '0; sp = '0;
    t_reset();
    t_basic();
    t_stop();
    t_collide();
    t_both();
    t_indep();
    t_scale();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule